// File: doc/BRIEF.md
# Dual-Clock Line Delay Buffer

This block is a sequential-access line memory with an independent write side and read side. Each side has its own clock, an active-low enable and an active-high synchronous pointer reset. Neither side takes an address. Each side keeps an internal pointer that advances by one on every enabled edge and wraps to zero after the last word of the line. The line length does not have to be a power of two, and the default is 5048 words of 8 bits.

The usual use is a one-line delay for raster data. When both sides share a clock and stay enabled, every word comes out of the read port exactly one line after it went in. No FIFO status is produced, and nothing guards against one pointer overtaking the other. The system sets the relationship between the two pointers by choosing when it releases each reset. Read data is held in a register clocked by the read clock.

Top module: `line_delay_mem`

## Requirements
- R1: The storage holds DEPTH words of W bits (defaults 5048 and 8). Each pointer counts 0, 1, …, DEPTH-1 and then returns to 0 and keeps counting, including when DEPTH is not a power of two.
- R2: On a wr_clk rising edge with wr_en_n low and wr_rst low, wr_data is stored at the write pointer and the pointer advances. With wr_en_n high, nothing is stored and the write pointer keeps its value.
- R3: On an rd_clk rising edge with rd_en_n low and rd_rst low, the word at the read pointer is read and the pointer advances. With rd_en_n high, the read pointer keeps its value.
- R4: rd_data is a register. It shows the word read at an enabled rd_clk edge from just after that edge onward, and it keeps its last value through any rd_clk edge that performs no read.
- R5: wr_rst is synchronous to wr_clk and overrides wr_en_n. On an edge where it is high, the write pointer becomes 0 and no word is stored. The next enabled write goes to address 0.
- R6: rd_rst is synchronous to rd_clk and overrides rd_en_n. On an edge where it is high, the read pointer becomes 0, no read happens and rd_data is unchanged. The next enabled read returns address 0.
- R7: The two sides are independent. Resetting one pointer at any point in a line leaves the other pointer and the stored words unchanged.
- R8: A read and a write to the same address on the same shared edge return the word stored before that edge. With one clock on both sides, both enables low and both pointers starting together, rd_data after edge i+DEPTH equals the wr_data taken at edge i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write pointer reset, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | W | Word to be stored |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous read pointer reset, active high |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | W | Registered read word |

## Verification
The pointer wrap is the hardest condition to reach from the ports. It only shows after a full line of DEPTH enabled edges, and it only becomes visible once the words of the second line come out. The bench drives both sides from one clock for two full lines with a position-dependent pattern, so every word of the second half must match the word written exactly one line earlier, across the 5047-to-0 wrap. Directed sequences cover the other cases. These include holding an enable high while the other inputs toggle, asserting a reset with its enable still low in the middle of a line, and resetting one side while the other keeps running.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

   // address width that can hold every index of a line of depth d
   function automatic int unsigned ptr_bits(input int unsigned d);
      return (d <= 1) ? 1 : $clog2(d);
   endfunction

   function automatic bit is_pow2(input int unsigned d);
      return (d != 0) && ((d & (d - 1)) == 0);
   endfunction

endpackage

// File: rtl/ldm_seq_ptr.sv
module ldm_seq_ptr #(
   parameter int unsigned DEPTH = 5048,
   parameter int unsigned AW    = ldm_pkg::ptr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   output logic [AW-1:0] ptr
);
   localparam bit          IS_POW2 = ldm_pkg::is_pow2(DEPTH);
   localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

   logic [AW-1:0] nxt;

   generate
      if (IS_POW2) begin : g_natural
         // wrap falls out of the counter width
         assign nxt = ptr + 1'b1;
      end else begin : g_compare
         assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       ptr <= '0;
      else if (step) ptr <= nxt;
   end
endmodule

// File: rtl/ldm_line_ram.sv
module ldm_line_ram #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 5048,
   parameter int unsigned AW    = ldm_pkg::ptr_bits(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   // read-before-write on a shared edge: old word comes out
   always_ff @(posedge rclk) begin
      if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 5048
) (
   input  logic         wr_clk,
   input  logic         wr_rst,
   input  logic         wr_en_n,
   input  logic [W-1:0] wr_data,
   input  logic         rd_clk,
   input  logic         rd_rst,
   input  logic         rd_en_n,
   output logic [W-1:0] rd_data
);
   localparam int unsigned AW = ldm_pkg::ptr_bits(DEPTH);

   generate
      if (W < 1) begin : g_bad_width
         $error("line_delay_mem: W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("line_delay_mem: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0] wptr;
   logic [AW-1:0] rptr;
   logic          wr_go;
   logic          rd_go;

   // reset outranks enable on each side
   assign wr_go = ~wr_en_n & ~wr_rst;
   assign rd_go = ~rd_en_n & ~rd_rst;

   ldm_seq_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk  (wr_clk),
      .rst  (wr_rst),
      .step (wr_go),
      .ptr  (wptr)
   );

   ldm_seq_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk  (rd_clk),
      .rst  (rd_rst),
      .step (rd_go),
      .ptr  (rptr)
   );

   ldm_line_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .wclk  (wr_clk),
      .we    (wr_go),
      .waddr (wptr),
      .wdata (wr_data),
      .rclk  (rd_clk),
      .re    (rd_go),
      .raddr (rptr),
      .rdata (rd_data)
   );
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 5048,
   parameter int unsigned AW    = 13
) (
   input logic          wr_clk,
   input logic          wr_rst,
   input logic          wr_en_n,
   input logic [AW-1:0] wptr,
   input logic          rd_clk,
   input logic          rd_rst,
   input logic          rd_en_n,
   input logic [AW-1:0] rptr,
   input logic [W-1:0]  rd_data
);
   logic w_ok = 1'b0;
   logic r_ok = 1'b0;

   always_ff @(posedge wr_clk) if (wr_rst) w_ok <= 1'b1;
   always_ff @(posedge rd_clk) if (rd_rst) r_ok <= 1'b1;

   AST_WPTR_RANGE: assert property (@(posedge wr_clk) disable iff (!w_ok)
      32'(wptr) < DEPTH); // R1
   AST_WPTR_STEP: assert property (@(posedge wr_clk) disable iff (!w_ok)
      (!wr_rst && !wr_en_n) |=> (32'(wptr) ==
         ((32'($past(wptr)) == DEPTH - 1) ? 32'd0 : 32'($past(wptr)) + 32'd1))); // R1
   AST_WPTR_HOLD: assert property (@(posedge wr_clk) disable iff (!w_ok)
      (!wr_rst && wr_en_n) |=> $stable(wptr)); // R2
   AST_RPTR_HOLD: assert property (@(posedge rd_clk) disable iff (!r_ok)
      (!rd_rst && rd_en_n) |=> $stable(rptr)); // R3
   AST_RPTR_STEP: assert property (@(posedge rd_clk) disable iff (!r_ok)
      (!rd_rst && !rd_en_n) |=> (32'(rptr) ==
         ((32'($past(rptr)) == DEPTH - 1) ? 32'd0 : 32'($past(rptr)) + 32'd1))); // R1
   AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!r_ok)
      (rd_rst || rd_en_n) |=> $stable(rd_data)); // R4
   AST_WPTR_ZERO: assert property (@(posedge wr_clk) disable iff (!w_ok)
      wr_rst |=> (wptr == '0)); // R5
   AST_RPTR_ZERO: assert property (@(posedge rd_clk) disable iff (!r_ok)
      rd_rst |=> (rptr == '0)); // R6
endmodule

bind line_delay_mem ldm_checker #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_chk (
   .wr_clk  (wr_clk),
   .wr_rst  (wr_rst),
   .wr_en_n (wr_en_n),
   .wptr    (wptr),
   .rd_clk  (rd_clk),
   .rd_rst  (rd_rst),
   .rd_en_n (rd_en_n),
   .rptr    (rptr),
   .rd_data (rd_data)
);

// File: tb/sim_line_delay_mem.sv
`timescale 1ns/1ps
module sim_line_delay_mem;
   localparam int W = 8;
   localparam int D = 5048;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic         wr_rst  = 1'b0;
   logic         wr_en_n = 1'b1;
   logic [W-1:0] wr_data = '0;
   logic         rd_rst  = 1'b0;
   logic         rd_en_n = 1'b1;
   logic [W-1:0] rd_data;

   line_delay_mem #(.W(W), .DEPTH(D)) u0 (
      .wr_clk(clk), .wr_rst(wr_rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
      .rd_clk(clk), .rd_rst(rd_rst), .rd_en_n(rd_en_n), .rd_data(rd_data)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // requirement-level model of the line memory
   logic [W-1:0] m_mem [D];
   int           m_wp = 0;
   int           m_rp = 0;
   logic [W-1:0] m_q  = '0;

   function automatic int inc(input int p);
      return (p == D - 1) ? 0 : p + 1;
   endfunction

   function automatic logic [W-1:0] pat(input int i);
      return W'(i * 37 + i / 256);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit wn, input logic [W-1:0] wd, input bit rn,
                       input bit wr, input bit rr);
      @(negedge clk);
      wr_en_n = wn; wr_data = wd; rd_en_n = rn; wr_rst = wr; rd_rst = rr;
      @(posedge clk);
      #1;
      if (rr) m_rp = 0;
      else if (!rn) begin m_q = m_mem[m_rp]; m_rp = inc(m_rp); end
      if (wr) m_wp = 0;
      else if (!wn) begin m_mem[m_wp] = wd; m_wp = inc(m_wp); end
   endtask

   task automatic both_reset();
      step(1'b1, '0, 1'b1, 1'b1, 1'b1);
   endtask

   // R8 and R1: two full lines through one shared clock
   task automatic t_line_delay();
      for (int k = 0; k < 3; k++) both_reset();
      for (int i = 0; i < 2 * D; i++) begin
         step(1'b0, pat(i), 1'b0, 1'b0, 1'b0);
         if (i >= D) check("R8", rd_data, pat(i - D));
         if (i == D || i == 2 * D - 1) check("R1", rd_data, pat(i - D));
      end
   endtask

   // R2, R3, R4: enables high hold pointers and output
   task automatic t_hold();
      logic [W-1:0] kept;
      both_reset();
      for (int k = 0; k < 10; k++) step(1'b0, 8'hA0 + W'(k), 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 5; k++)  step(1'b1, 8'hFF, 1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++)  step(1'b0, 8'hB0 + W'(k), 1'b1, 1'b0, 1'b0);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R6", rd_data, 8'hA0);
      for (int k = 0; k < 3; k++) begin
         step(1'b1, '0, 1'b0, 1'b0, 1'b0);
         check("R3", rd_data, m_q);
      end
      kept = rd_data;
      for (int k = 0; k < 6; k++) begin
         step(1'b1, 8'h77, 1'b1, 1'b0, 1'b0);
         check("R4", rd_data, kept);
      end
      for (int k = 4; k < 13; k++) begin
         step(1'b1, '0, 1'b0, 1'b0, 1'b0);
         check("R3", rd_data, (k < 10) ? 8'hA0 + W'(k) : 8'hB0 + W'(k - 10));
         if (k == 10) check("R2", rd_data, 8'hB0);
      end
   endtask

   // R5, R6: reset mid-line overrides a low enable
   task automatic t_mid_reset();
      logic [W-1:0] kept;
      both_reset();
      for (int k = 0; k < 20; k++) step(1'b0, 8'h10 + W'(k), 1'b1, 1'b0, 1'b0);
      step(1'b0, 8'h55, 1'b1, 1'b1, 1'b0);
      step(1'b0, 8'hC1, 1'b1, 1'b0, 1'b0);
      step(1'b0, 8'hC2, 1'b1, 1'b0, 1'b0);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);   // advances read pointer to 1
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);   // read pointer 2
      kept = rd_data;
      step(1'b1, '0, 1'b0, 1'b0, 1'b1);
      check("R6", rd_data, kept);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R5", rd_data, 8'hC1);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R5", rd_data, 8'hC2);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R5", rd_data, 8'h12);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R5", rd_data, 8'h13);
   endtask

   // R7: each side resets without disturbing the other
   task automatic t_indep();
      step(1'b0, 8'hD0, 1'b0, 1'b1, 1'b0);
      check("R7", rd_data, 8'h14);
      step(1'b0, 8'hD1, 1'b0, 1'b0, 1'b0);
      check("R7", rd_data, 8'h15);
      step(1'b0, 8'hD2, 1'b1, 1'b0, 1'b1);
      step(1'b0, 8'hD3, 1'b0, 1'b0, 1'b0);
      check("R7", rd_data, 8'hD1);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R7", rd_data, 8'hD2);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R7", rd_data, 8'hD3);
      step(1'b1, '0, 1'b0, 1'b0, 1'b0);
      check("R7", rd_data, m_q);
   endtask

   initial begin
      t_line_delay();
      t_hold();
      t_mid_reset();
      t_indep();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule